// File: doc/BRIEF.md
# SMI Gating and Monitor Control Unit

This unit decides, cycle by cycle, whether a processor core may accept a system-management interrupt (SMI). It holds a small monitor-control register that software reaches through an indexed register-access port, and it follows whether the core is inside the secured-execution mode. One-cycle event pulses update the SMI-blocked flag. These events are an SMI being taken, a return-from-SMM entry, a virtualization-off event, and entering or leaving secure mode. The unit also accepts or rejects monitor-call requests, based on the valid bit of the register.

A return-from-SMM entry chooses the new blocked state by one of two rules. When the deactivate-dual-monitor control is low, the rule follows the guest interruptibility-state word. When that control is high, the rule follows the secure-mode state. A virtualization-off event normally lifts the block. A suppress bit in the register stops this, and the valid bit has no effect on it. A separate secure-command pulse clears the suppress bit.

Top module: `smi_gate_ctl`

## Requirements
- R1: After reset the monitor-control register reads 0 and smi_blocked, in_secure_mode, call_accept and call_fault are all 0.
- R2: The register answers at index 0x9B only. A write with reg_wr_en high and that index updates it, and the new value reads back on reg_rdata from the next cycle. At any other index reg_rdata is 0 and writes change nothing.
- R3: Only bit 0 (valid) and bit 2 (suppress) are stored. Bit 1 and every bit above 2 read as 0, whatever was written to them.
- R4: A call_req pulse gives, one cycle later, exactly one of two pulses. call_accept comes if bit 0 was 1 in the request cycle. call_fault comes if bit 0 was 0.
- R5: A virtualization-off pulse with no higher-priority event clears smi_blocked on the next cycle when bit 2 is 0. When bit 2 is 1, smi_blocked is left unchanged. Bit 0 plays no part in this.
- R6: A return-from-SMM pulse with deactivate_dual at 0 and no SMI taken sets smi_blocked to bit 2 of int_state.
- R7: A return-from-SMM pulse with deactivate_dual at 1 and no SMI taken sets smi_blocked to the in_secure_mode value of that cycle.
- R8: A secure-enter pulse sets in_secure_mode and a secure-exit pulse clears it. When both arrive in the same cycle, the exit wins.
- R9: A secure-command clear pulse clears bit 2 on the next cycle, even when a register write arrives in the same cycle.
- R10: An SMI-taken pulse sets smi_blocked to 1. Priority among the events is SMI taken, then return-from-SMM, then virtualization-off.
- R11: With none of those three events, smi_blocked holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_index | input | IDX_W | Register index for read and write |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_index |
| ev_smi_taken | input | 1 | SMI taken pulse |
| ev_smm_return | input | 1 | Return-from-SMM entry pulse |
| ev_virt_off | input | 1 | Virtualization-off pulse |
| ev_secure_enter | input | 1 | Secure-mode enter pulse |
| ev_secure_exit | input | 1 | Secure-mode exit pulse |
| ev_secure_clr | input | 1 | Secure command clearing bit 2 |
| deactivate_dual | input | 1 | Selects the return-from-SMM rule |
| int_state | input | IS_W | Guest interruptibility-state word |
| call_req | input | 1 | Monitor-call request pulse |
| call_accept | output | 1 | Request accepted, one cycle later |
| call_fault | output | 1 | Request rejected, one cycle later |
| smi_blocked | output | 1 | SMIs currently blocked |
| in_secure_mode | output | 1 | Core inside secured execution |

## Verification
The blocked flag is driven with random mixes of the three events. These mixes cover single events, collisions that show the priority order, and return-from-SMM with both settings of deactivate_dual under changing int_state and secure-mode states, which separates the two rules. Virtualization-off is tried with all four combinations of the valid and suppress bits, so a design that wrongly gates on bit 0 is caught. Directed cases cover a write racing a clear, enter and exit together, writes to a foreign index, and all-ones write data that exposes stored reserved bits.

// File: rtl/smi_gate_pkg.sv
package smi_gate_pkg;

  localparam int unsigned VALID_POS    = 0;
  localparam int unsigned SUPPRESS_POS = 2;
  localparam int unsigned IS_SMI_POS   = 2;

  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_SMI     = 3'd1,
    CAUSE_RET_IS  = 3'd2,
    CAUSE_RET_SEC = 3'd3,
    CAUSE_VOFF    = 3'd4,
    CAUSE_VOFF_KEEP = 3'd5
  } blk_cause_e;

  // Event priority: SMI taken, then return-from-SMM, then virtualization-off.
  function automatic blk_cause_e pick_cause(
    input logic smi, input logic ret, input logic deact,
    input logic voff, input logic suppress);
    if (smi)              return CAUSE_SMI;
    else if (ret)         return deact ? CAUSE_RET_SEC : CAUSE_RET_IS;
    else if (voff)        return suppress ? CAUSE_VOFF_KEEP : CAUSE_VOFF;
    else                  return CAUSE_NONE;
  endfunction

  function automatic logic next_block(
    input blk_cause_e cause, input logic cur,
    input logic sec, input logic is_bit);
    case (cause)
      CAUSE_SMI:     return 1'b1;
      CAUSE_RET_IS:  return is_bit;
      CAUSE_RET_SEC: return sec;
      CAUSE_VOFF:    return 1'b0;
      default:       return cur;
    endcase
  endfunction

endpackage

// File: rtl/mon_ctl_reg.sv
module mon_ctl_reg
  import smi_gate_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr_suppress,
  output logic              valid_q,
  output logic              suppress_q,
  output logic [DATA_W-1:0] rdata
);

  function automatic logic [DATA_W-1:0] pack_ctl(input logic v, input logic s);
    logic [DATA_W-1:0] w;
    w = '0;
    w[VALID_POS]    = v;
    w[SUPPRESS_POS] = s;
    return w;
  endfunction

  logic valid_d, suppress_d;
  logic unused_wdata;
  assign unused_wdata = ^{wdata[DATA_W-1:SUPPRESS_POS+1], wdata[1]};

  always_comb begin
    valid_d    = valid_q;
    suppress_d = suppress_q;
    if (wr_hit) begin
      valid_d    = wdata[VALID_POS];
      suppress_d = wdata[SUPPRESS_POS];
    end
    if (clr_suppress) suppress_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q    <= 1'b0;
      suppress_q <= 1'b0;
    end else begin
      valid_q    <= valid_d;
      suppress_q <= suppress_d;
    end
  end

  assign rdata = rd_hit ? pack_ctl(valid_q, suppress_q) : '0;

  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_suppress |=> !suppress_q);
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[1] == 1'b0) && (rdata >> (SUPPRESS_POS + 1)) == '0);
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !clr_suppress) |=> (valid_q == $past(wdata[VALID_POS]))
                                 && (suppress_q == $past(wdata[SUPPRESS_POS])));

endmodule

// File: rtl/secure_track.sv
module secure_track (
  input  logic clk,
  input  logic rst_n,
  input  logic enter,
  input  logic leave,
  output logic secure_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)      secure_q <= 1'b0;
    else if (leave)  secure_q <= 1'b0;
    else if (enter)  secure_q <= 1'b1;
  end

  a_r8_leave_clears: assert property (@(posedge clk) disable iff (!rst_n)
    leave |=> !secure_q);
  a_r8_enter_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (enter && !leave) |=> secure_q);

endmodule

// File: rtl/smi_block_unit.sv
module smi_block_unit
  import smi_gate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic smi_taken,
  input  logic smm_return,
  input  logic virt_off,
  input  logic deactivate,
  input  logic suppress,
  input  logic secure,
  input  logic is_smi_bit,
  output blk_cause_e cause,
  output logic blocked_q
);

  logic blocked_d;

  assign cause     = pick_cause(smi_taken, smm_return, deactivate, virt_off, suppress);
  assign blocked_d = next_block(cause, blocked_q, secure, is_smi_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) blocked_q <= 1'b0;
    else        blocked_q <= blocked_d;
  end

  a_r10_smi_sets: assert property (@(posedge clk) disable iff (!rst_n)
    smi_taken |=> blocked_q);
  a_r5_voff_unblocks: assert property (@(posedge clk) disable iff (!rst_n)
    (virt_off && !smi_taken && !smm_return && !suppress) |=> !blocked_q);
  a_r5_voff_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (virt_off && !smi_taken && !smm_return && suppress) |=> $stable(blocked_q));
  a_r7_ret_secure: assert property (@(posedge clk) disable iff (!rst_n)
    (smm_return && !smi_taken && deactivate) |=> blocked_q == $past(secure));
  a_r6_ret_state: assert property (@(posedge clk) disable iff (!rst_n)
    (smm_return && !smi_taken && !deactivate) |=> blocked_q == $past(is_smi_bit));
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!smi_taken && !smm_return && !virt_off) |=> $stable(blocked_q));

endmodule

// File: rtl/call_gate.sv
module call_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic valid,
  output logic accept_q,
  output logic fault_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accept_q <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      accept_q <= req & valid;
      fault_q  <= req & ~valid;
    end
  end

  a_r4_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept_q && fault_q));
  a_r4_accept_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (accept_q == $past(valid)) && (fault_q == !$past(valid)));
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !accept_q && !fault_q);

endmodule

// File: rtl/smi_gate_ctl.sv
module smi_gate_ctl
  import smi_gate_pkg::*;
#(
  parameter int unsigned IDX_W     = 12,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned IS_W      = 32,
  parameter logic [IDX_W-1:0] MON_INDEX = 12'h09B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  reg_index,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_smi_taken,
  input  logic              ev_smm_return,
  input  logic              ev_virt_off,
  input  logic              ev_secure_enter,
  input  logic              ev_secure_exit,
  input  logic              ev_secure_clr,
  input  logic              deactivate_dual,
  input  logic [IS_W-1:0]   int_state,
  input  logic              call_req,
  output logic              call_accept,
  output logic              call_fault,
  output logic              smi_blocked,
  output logic              in_secure_mode
);

  logic       idx_hit, wr_hit;
  logic       ctl_valid, ctl_suppress;
  logic       secure_q;
  blk_cause_e blk_cause;
  logic       unused_is;

  assign idx_hit   = (reg_index == MON_INDEX);
  assign wr_hit    = idx_hit & reg_wr_en;
  assign unused_is = ^{int_state, blk_cause};

  mon_ctl_reg #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .rd_hit(idx_hit),
    .wdata(reg_wdata), .clr_suppress(ev_secure_clr),
    .valid_q(ctl_valid), .suppress_q(ctl_suppress), .rdata(reg_rdata)
  );

  secure_track u_sec (
    .clk(clk), .rst_n(rst_n), .enter(ev_secure_enter),
    .leave(ev_secure_exit), .secure_q(secure_q)
  );

  smi_block_unit u_blk (
    .clk(clk), .rst_n(rst_n), .smi_taken(ev_smi_taken),
    .smm_return(ev_smm_return), .virt_off(ev_virt_off),
    .deactivate(deactivate_dual), .suppress(ctl_suppress),
    .secure(secure_q), .is_smi_bit(int_state[IS_SMI_POS]),
    .cause(blk_cause), .blocked_q(smi_blocked)
  );

  call_gate u_call (
    .clk(clk), .rst_n(rst_n), .req(call_req), .valid(ctl_valid),
    .accept_q(call_accept), .fault_q(call_fault)
  );

  assign in_secure_mode = secure_q;

  a_r2_foreign_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_hit |-> reg_rdata == '0);

endmodule

// File: tb/smi_gate_ctl_bench.sv
module smi_gate_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 12, DATA_W = 64, IS_W = 32;
  localparam logic [IDX_W-1:0] MON = 12'h09B;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [IDX_W-1:0] reg_index = '0;
  logic reg_wr_en = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0, reg_rdata;
  logic ev_smi = 0, ev_ret = 0, ev_voff = 0, ev_ent = 0, ev_ext = 0, ev_clr = 0;
  logic deact = 0, call_req = 0;
  logic [IS_W-1:0] int_state = '0;
  logic call_accept, call_fault, smi_blocked, in_secure_mode;

  int checks = 0, fails = 0;
  bit done = 0;
  logic mv = 0, ms = 0, mblk = 0, msec = 0, macc = 0, mflt = 0;
  string blk_tag = "R1", rd_tag = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  smi_gate_ctl u_smi_gate_ctl (
    .clk(clk), .rst_n(rst_n), .reg_index(reg_index), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_smi_taken(ev_smi),
    .ev_smm_return(ev_ret), .ev_virt_off(ev_voff), .ev_secure_enter(ev_ent),
    .ev_secure_exit(ev_ext), .ev_secure_clr(ev_clr), .deactivate_dual(deact),
    .int_state(int_state), .call_req(call_req), .call_accept(call_accept),
    .call_fault(call_fault), .smi_blocked(smi_blocked), .in_secure_mode(in_secure_mode)
  );

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] exp_read(input logic [IDX_W-1:0] idx);
    logic [DATA_W-1:0] r = '0;
    if (idx == MON) begin r[0] = mv; r[2] = ms; end
    return r;
  endfunction

  function automatic logic exp_block;
    if (ev_smi) return 1'b1;
    if (ev_ret) return deact ? msec : int_state[2];
    if (ev_voff && !ms) return 1'b0;
    return mblk;
  endfunction

  function automatic string tag_block;
    if (ev_smi) return "R10";
    if (ev_ret) return deact ? "R7" : "R6";
    if (ev_voff) return "R5";
    return "R11";
  endfunction

  // Outputs of the cycle just completed, then drive the next inputs.
  task automatic cycle_check;
    chk(blk_tag, smi_blocked, mblk);
    chk("R8", in_secure_mode, msec);
    chk("R4", {call_accept, call_fault}, {macc, mflt});
  endtask

  task automatic apply_and_model;
    logic hit;
    #1;
    chk(rd_tag, reg_rdata, exp_read(reg_index));
    if (reg_index == MON) chk("R3", reg_rdata & ~64'h5, '0);
    hit = reg_wr_en && reg_index == MON;
    blk_tag = tag_block();
    mblk = exp_block();
    macc = call_req & mv;
    mflt = call_req & ~mv;
    msec = ev_ext ? 1'b0 : (ev_ent ? 1'b1 : msec);
    if (hit) mv = reg_wdata[0];
    ms = ev_clr ? 1'b0 : (hit ? reg_wdata[2] : ms);
    rd_tag = ev_clr ? "R9" : "R2";
    @(negedge clk);
    cycle_check();
  endtask

  task automatic idle;
    reg_wr_en = 0; ev_smi = 0; ev_ret = 0; ev_voff = 0; ev_ent = 0;
    ev_ext = 0; ev_clr = 0; call_req = 0; reg_index = MON;
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h5A17);
    repeat (3) @(negedge clk);
    chk("R1", smi_blocked, 0); chk("R1", in_secure_mode, 0);
    chk("R1", {call_accept, call_fault}, 0);
    reg_index = MON; #1; chk("R1", reg_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: all-ones write stores only bits 0 and 2
    idle(); reg_wr_en = 1; reg_wdata = '1; apply_and_model();
    idle(); apply_and_model();
    // R2: foreign index write ignored, reads zero
    idle(); reg_index = 12'h09A; reg_wr_en = 1; reg_wdata = '0; apply_and_model();
    idle(); apply_and_model();
    // R9: clear racing a write of bit 2
    idle(); reg_wr_en = 1; reg_wdata = 64'h4; ev_clr = 1; apply_and_model();
    idle(); apply_and_model();
    // R4: call with valid 0 faults
    idle(); call_req = 1; apply_and_model();
    idle(); apply_and_model();
    // R5: suppress=1 with valid=0 keeps the block
    idle(); ev_smi = 1; reg_wr_en = 1; reg_wdata = 64'h4; apply_and_model();
    idle(); ev_voff = 1; apply_and_model();
    idle(); apply_and_model();
    // R8: enter and exit together
    idle(); ev_ent = 1; apply_and_model();
    idle(); ev_ent = 1; ev_ext = 1; apply_and_model();
    // R10: SMI with return and virt-off together
    idle(); ev_smi = 1; ev_ret = 1; ev_voff = 1; deact = 0; int_state = '0; apply_and_model();
    idle(); apply_and_model();

    for (int i = 0; i < 3000; i++) begin
      idle();
      reg_index = ($urandom_range(0, 7) == 0) ? IDX_W'($urandom) : MON;
      reg_wr_en = ($urandom_range(0, 5) == 0);
      reg_wdata = {$urandom, $urandom};
      ev_smi  = ($urandom_range(0, 7) == 0);
      ev_ret  = ($urandom_range(0, 4) == 0);
      ev_voff = ($urandom_range(0, 4) == 0);
      ev_ent  = ($urandom_range(0, 6) == 0);
      ev_ext  = ($urandom_range(0, 8) == 0);
      ev_clr  = ($urandom_range(0, 12) == 0);
      call_req = ($urandom_range(0, 3) == 0);
      deact = $urandom_range(0, 1);
      int_state = $urandom;
      apply_and_model();
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule